// File: doc/BRIEF.md
# Multi-Channel Reloadable Timer Unit

This block groups two or three independent down-counting timer channels behind one small register window. A requester issues single-cycle accesses with a byte address. The decoder sends each access to one of four places: a one-bit output-control register, a shared start register, or the register set of one channel. In the start register, each channel has its own run bit. Clearing a run bit freezes that channel, and setting it again lets the channel carry on from where it stopped.

Each channel has a reload value, a live count, a control word and, on the third channel only, a capture word. When the channel is running, a prescaler divides the clock. Each prescaler period takes one from the count. When the count is already zero at a period boundary, the channel loads the reload value and latches an underflow flag. The flag drives that channel's interrupt output if the interrupt is enabled. A parameter decides whether the third channel exists. Another parameter decides whether the output-control register exists. Accesses to absent or unmapped places return zero and raise an error.

Top module: `multi_timer_unit`

## Requirements
- R1: Byte offsets decode as follows. 0x00 is output control and 0x04 is start. Channel 0 covers 0x08-0x13, channel 1 covers 0x14-0x1F and channel 2 covers 0x20-0x2F, with each channel's base taken off. Within a channel, word 0 is the reload value, word 1 the count, word 2 control and word 3 capture. Address bits 1:0 are ignored.
- R2: The output-control register keeps only bit 0, and it reads back on bit 0 with the other bits zero. When the register is configured absent, offset 0x00 is illegal.
- R3: The start register keeps bits 2:0, where bit n is channel n's run bit. It reads back the stored bits, with the other bits zero.
- R4: While a channel's run bit is 0, its count and its prescaler phase hold. Setting the bit again resumes from the held prescaler phase.
- R5: Starting or stopping one channel leaves the other channels' counts and prescalers unchanged.
- R6: Control bits 2:0 select the prescale: values 0 to 4 divide by 4, 16, 64, 256 and 1024. A running channel loses one count per period. A control write clears the prescaler, so the first decrement comes one full period after the run starts. Values 5 to 7 are an illegal write.
- R7: At a period boundary with the count at zero, the count loads the reload value and control bit 8 (underflow flag) is set.
- R8: The interrupt output equals the flag AND control bit 5 (enable). Writing 0 to bit 8 clears the flag, and writing 1 to bit 8 has no effect.
- R9: When an underflow and a control write that clears the flag fall in the same cycle, the flag ends up set.
- R10: Only channel 2 has the capture word (offset 0x2C), which can be written and read back. It resets to 0.
- R11: With channel 2 absent, any access at 0x20 or above is illegal, a start write with bit 2 = 1 is illegal, and interrupt bit 2 stays 0.
- R12: An illegal or unmapped access returns read data 0 and raises the error flag. An illegal write changes no state.
- R13: Every request gets a response in the next cycle, carrying the data as it was in the request cycle. Reset values: reload and count all ones, control 0, start 0, output control 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 on writes and errors) |
| rsp_err | output | 1 | Previous request was illegal or unmapped |
| irq | output | 3 | Per-channel interrupt, bit n for channel n |
| out_ctrl | output | 1 | Stored output-control bit |

## Verification
An underflow and a software write that clears the flag can land on the same clock edge. The bench sets this up exactly: it loads a zero count, starts the channel from a cleared prescaler, and issues the clearing control write on the fourth edge after the start write, which is the edge where the first period ends. It then judges the result by reading the control word and watching the interrupt pin: the flag must be set and the count reloaded. A second overlap is tested too. Stopping one channel's run bit on a period boundary must still let that last decrement happen, and must leave a neighbour channel counting undisturbed.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
   localparam int PSC_W        = 10;
   localparam int CTRL_IE_BIT  = 5;
   localparam int CTRL_FLG_BIT = 8;
   localparam logic [2:0] SEL_MAX = 3'd4;

   // terminal value of the prescaler for a given select (divide by 4^(sel+1))
   function automatic logic [PSC_W-1:0] psc_last(input logic [2:0] sel);
      logic [PSC_W-1:0] v;
      v = '0;
      for (int k = 0; k < PSC_W; k++)
         if (k < 2 + 2 * int'(sel)) v[k] = 1'b1;
      return v;
   endfunction

   function automatic int chan_base(input int idx);
      return (idx == 0) ? 8 : (idx == 1) ? 20 : 32;
   endfunction

   function automatic int chan_end(input int idx);
      return (idx == 0) ? 20 : (idx == 1) ? 32 : 48;
   endfunction
endpackage

// File: rtl/mtu_prescale.sv
module mtu_prescale
   import mtu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       clr,
   input  logic [2:0] sel,
   output logic       tick
);
   logic [PSC_W-1:0] phase_q;

   assign tick = en && (phase_q == psc_last(sel));

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  phase_q <= '0;
      else if (en)        phase_q <= tick ? '0 : phase_q + 1'b1;
   end

   // phase is frozen while the channel is stopped
   assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(phase_q));
endmodule

// File: rtl/mtu_channel.sv
module mtu_channel
   import mtu_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter bit HAS_CAPT = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        sel,
   input  logic        wr,
   input  logic [1:0]  word,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        bad,
   output logic        irq
);
   if (CNT_W < 8 || CNT_W > 32) begin : g_bad_width
      $error("mtu_channel: CNT_W must lie in 8..32");
   end

   logic [CNT_W-1:0] reload_q, count_q;
   logic [2:0]       psel_q;
   logic             ie_q, flag_q;
   logic [31:0]      capt_val;
   logic             do_wr, tick, unf, ctl_wr, cnt_wr;

   assign bad    = (word == 2'd3 && !HAS_CAPT) ||
                   (wr && word == 2'd2 && wdata[2:0] > SEL_MAX);
   assign do_wr  = sel && wr && !bad;
   assign ctl_wr = do_wr && word == 2'd2;
   assign cnt_wr = do_wr && word == 2'd1;
   assign unf    = tick && (count_q == '0);

   mtu_prescale u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (run),
      .clr  (ctl_wr),
      .sel  (psel_q),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '1;
         count_q  <= '1;
         psel_q   <= '0;
         ie_q     <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         if (do_wr && word == 2'd0) reload_q <= wdata[CNT_W-1:0];
         if (cnt_wr)                count_q  <= wdata[CNT_W-1:0];
         else if (tick)             count_q  <= unf ? reload_q : count_q - 1'b1;
         if (ctl_wr) begin
            psel_q <= wdata[2:0];
            ie_q   <= wdata[CTRL_IE_BIT];
         end
         if (unf)                                 flag_q <= 1'b1;
         else if (ctl_wr && !wdata[CTRL_FLG_BIT]) flag_q <= 1'b0;
      end
   end

   if (HAS_CAPT) begin : g_capt
      logic [31:0] capt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                     capt_q <= '0;
         else if (do_wr && word == 2'd3) capt_q <= wdata;
      end
      assign capt_val = capt_q;
   end else begin : g_no_capt
      assign capt_val = '0;
   end

   assign irq = flag_q && ie_q;

   always_comb begin
      case (word)
         2'd0:    rdata = 32'(reload_q);
         2'd1:    rdata = 32'(count_q);
         2'd2:    rdata = {23'b0, flag_q, 2'b0, ie_q, 2'b0, psel_q};
         default: rdata = capt_val;
      endcase
   end

   assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(count_q));
   assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count_q != '0 && !cnt_wr) |=> count_q == $past(count_q) - 1'b1);
   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (unf && !cnt_wr) |=> count_q == $past(reload_q));
   assert_flag_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> flag_q);
endmodule

// File: rtl/multi_timer_unit.sv
module multi_timer_unit
   import mtu_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int CNT_W      = 32,
   parameter bit HAS_CH2    = 1'b1,
   parameter bit HAS_OUTCTL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_err,
   output logic [2:0]        irq,
   output logic              out_ctrl
);
   localparam int NCH = HAS_CH2 ? 3 : 2;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("multi_timer_unit: ADDR_W must be at least 6");
   end

   logic [2:0]  start_q;
   logic [2:0]  in_ch, ch_bad;
   logic [31:0] ch_rd [3];
   logic        is_outctl, is_start, bad;
   logic [31:0] rd_val;

   assign is_outctl = (req_addr[ADDR_W-1:2] == '0);
   assign is_start  = (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

   for (genvar i = 0; i < 3; i++) begin : g_ch
      if (i < NCH) begin : g_on
         localparam int BASE = chan_base(i);
         logic [ADDR_W-1:0] off;
         assign in_ch[i] = int'(req_addr) >= BASE && int'(req_addr) < chan_end(i);
         assign off      = req_addr - ADDR_W'(BASE);
         mtu_channel #(.CNT_W(CNT_W), .HAS_CAPT(i == 2)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (start_q[i]),
            .sel  (req_valid && in_ch[i]),
            .wr   (req_write),
            .word (off[3:2]),
            .wdata(req_wdata),
            .rdata(ch_rd[i]),
            .bad  (ch_bad[i]),
            .irq  (irq[i])
         );
      end else begin : g_off
         assign in_ch[i]  = 1'b0;
         assign ch_bad[i] = 1'b0;
         assign ch_rd[i]  = '0;
         assign irq[i]    = 1'b0;
      end
   end

   always_comb begin
      rd_val = '0;
      bad    = 1'b0;
      if (is_outctl) begin
         bad    = !HAS_OUTCTL;
         rd_val = {31'b0, out_ctrl};
      end else if (is_start) begin
         bad    = req_write && !HAS_CH2 && req_wdata[2];
         rd_val = {29'b0, start_q};
      end else if (|in_ch) begin
         for (int i = 0; i < 3; i++)
            if (in_ch[i]) begin
               bad    = ch_bad[i];
               rd_val = ch_rd[i];
            end
      end else begin
         bad = 1'b1;
      end
   end

   if (HAS_OUTCTL) begin : g_outctl
      logic oc_q;
      always_ff @(posedge clk) begin
         if (!rst_n) oc_q <= 1'b0;
         else if (req_valid && req_write && is_outctl) oc_q <= req_wdata[0];
      end
      assign out_ctrl = oc_q;
   end else begin : g_no_outctl
      assign out_ctrl = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (req_valid && req_write && is_start && !bad) start_q <= req_wdata[2:0];
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && bad;
         rsp_rdata <= (req_valid && !req_write && !bad) ? rd_val : '0;
      end
   end

   assert_err_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);
   assert_err_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_rdata == '0);
   assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_drop_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && is_start && bad) |=> $stable(start_q));
   if (!HAS_CH2) begin : g_chk_two
      assert_no_bit2_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !start_q[2] && !irq[2]);
   end
endmodule

// File: tb/multi_timer_unit_bench.sv
module multi_timer_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        m_vld, m_err, m_oc, l_vld, l_err, l_oc;
   logic [31:0] m_rd, l_rd;
   logic [2:0]  m_irq, l_irq;
   logic [31:0] got_m, got_l;
   logic        err_m, err_l;
   int checks = 0, errors = 0;

   localparam int C0 = 8, C1 = 20, C2 = 32;

   always #4 clk = ~clk;

   multi_timer_unit u_multi_timer_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(m_vld),
      .rsp_rdata(m_rd), .rsp_err(m_err), .irq(m_irq), .out_ctrl(m_oc));

   multi_timer_unit #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) u_multi_timer_unit_lite (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(l_vld),
      .rsp_rdata(l_rd), .rsp_err(l_err), .irq(l_irq), .out_ctrl(l_oc));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // one access; edge happens inside; returns at the following negedge
   task automatic bus(input logic wr, input int addr, input logic [31:0] d);
      req_valid = 1'b1; req_write = wr; req_addr = 6'(addr); req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      got_m = m_rd; err_m = m_err; got_l = l_rd; err_l = l_err;
      checks++;
      if (m_vld !== 1'b1) begin
         errors++;
         $display("FAIL R13: actual rsp_valid %0b expected 1", m_vld);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R13 irq", 32'(m_irq), 0);
      check("R13 out_ctrl", 32'(m_oc), 0);
      bus(0, 4, 0);         check("R13 start", got_m, 0);
      bus(0, C0 + 4, 0);    check("R13 count", got_m, 32'hFFFF_FFFF);
      bus(0, C1, 0);        check("R13 reload", got_m, 32'hFFFF_FFFF);
      bus(0, C2 + 8, 0);    check("R13 ctrl", got_m, 0);
      bus(0, C2 + 12, 0);   check("R10 capture reset", got_m, 0);
   endtask

   task automatic t_decode;
      bus(1, C0, 32'h11); bus(1, C1, 32'h22); bus(1, C2, 32'h33);
      bus(1, C0 + 4, 32'h44);
      bus(0, C0, 0);      check("R1 ch0 reload", got_m, 32'h11);
      bus(0, C1 + 3, 0);  check("R1 ch1 reload low bits", got_m, 32'h22);
      bus(0, C2, 0);      check("R1 ch2 reload", got_m, 32'h33);
      bus(0, C0 + 6, 0);  check("R1 ch0 count", got_m, 32'h44);
      bus(1, C2 + 12, 32'hCAFE_0123);
      bus(0, C2 + 12, 0); check("R10 capture rw", got_m, 32'hCAFE_0123);
      bus(1, 0, 32'hFF);  check("R2 out_ctrl pin", 32'(m_oc), 1);
      bus(0, 0, 0);       check("R2 out_ctrl read", got_m, 1);
      bus(1, 4, 32'hF8);
      bus(0, 4, 0);       check("R3 start keeps 2:0", got_m, 0);
   endtask

   task automatic t_illegal;
      bus(0, 48, 0);      check("R12 unmapped err", 32'(err_m), 1);
                          check("R12 unmapped data", got_m, 0);
      bus(1, C0 + 8, 32'h5);  check("R6 sel5 err", 32'(err_m), 1);
      bus(0, C0 + 8, 0);  check("R6 sel5 dropped", got_m, 0);
   endtask

   task automatic t_count;
      bus(1, C0 + 8, 0); bus(1, C1 + 8, 1);
      bus(1, C0 + 4, 10); bus(1, C1 + 4, 100);
      bus(1, 4, 3);                 // E0
      idle(19); bus(1, 4, 2);       // E20: stop ch0
      idle(19); bus(1, 4, 0);       // E40: stop ch1
      bus(0, 4, 0);      check("R3 start read", got_m, 0);
      bus(0, C0 + 4, 0); check("R6 ch0 div4 count", got_m, 5);
      bus(0, C1 + 4, 0); check("R5 ch1 div16 unaffected", got_m, 98);
      idle(10);
      bus(0, C0 + 4, 0); check("R4 held while stopped", got_m, 5);
      bus(1, 4, 1); idle(5); bus(1, 4, 0);   // 6 edges running
      bus(0, C0 + 4, 0); check("R4 resume", got_m, 4);
      bus(1, 4, 1); idle(1); bus(1, 4, 0);   // 2 edges, phase kept
      bus(0, C0 + 4, 0); check("R4 prescaler phase kept", got_m, 3);
      bus(0, C1 + 4, 0); check("R5 ch1 still held", got_m, 98);
   endtask

   task automatic t_underflow;
      bus(1, C0 + 8, 32'h20); bus(1, C0 + 4, 2); bus(1, C0, 7);
      bus(1, 4, 1);                 // E0; ticks E4, E8, E12 (reload)
      idle(11); check("R8 irq before underflow", 32'(m_irq[0]), 0);
      idle(1);  check("R7 irq after underflow", 32'(m_irq[0]), 1);
      bus(1, 4, 0);
      bus(0, C0 + 4, 0); check("R7 reloaded", got_m, 7);
      bus(0, C0 + 8, 0); check("R7 flag bit8", got_m, 32'h120);
      bus(1, C0 + 8, 32'h120); check("R8 write 1 no effect", 32'(m_irq[0]), 1);
      bus(1, C0 + 8, 32'h020); check("R8 clear", 32'(m_irq[0]), 0);
      bus(1, C1 + 8, 0); bus(1, C1 + 4, 0);
      bus(1, 4, 2); idle(7); bus(1, 4, 0);
      bus(0, C1 + 8, 0); check("R8 flag without enable", got_m, 32'h100);
      check("R8 irq masked", 32'(m_irq[1]), 0);
   endtask

   task automatic t_collide;
      bus(1, C2 + 8, 32'h20); bus(1, C2 + 4, 0); bus(1, C2, 9);
      bus(1, 4, 4);                 // E0
      idle(3); bus(1, C2 + 8, 32'h20);   // E4: underflow + clear
      check("R9 irq after collision", 32'(m_irq[2]), 1);
      bus(1, 4, 0);
      bus(0, C2 + 8, 0); check("R9 flag kept", got_m, 32'h120);
      bus(0, C2 + 4, 0); check("R9 count reloaded", got_m, 9);
      bus(1, C2 + 8, 32'h20); check("R8 clear ch2", 32'(m_irq[2]), 0);
   endtask

   task automatic t_lite;
      bus(0, C2, 0);  check("R11 ch2 absent err", 32'(err_l), 1);
                      check("R12 absent data", got_l, 0);
      bus(0, 0, 0);   check("R2 out_ctrl absent err", 32'(err_l), 1);
      bus(1, 4, 7);   check("R11 start bit2 err", 32'(err_l), 1);
      bus(0, 4, 0);   check("R12 dropped start write", got_l, 0);
      bus(1, 4, 3);   check("R11 legal start", 32'(err_l), 0);
      bus(0, 4, 0);   check("R3 lite start", got_l, 3);
      check("R11 irq2 low", 32'(l_irq[2]), 0);
      bus(1, 4, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decode();
      t_illegal();
      t_count();
      t_underflow();
      t_collide();
      t_lite();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule